// File: doc/BRIEF.md
# I2C Quad Wiper Register Slave

This block is a two-wire serial bus slave that owns four 8-bit wiper registers and a sixteen-entry, 8-bit shadow array that stands in for nonvolatile storage. Both bus lines are oversampled by the fast system clock. The block detects start and stop conditions, matches its 7-bit device address, and acknowledges by pulling the data line low through an open-drain enable output.

A write transfer carries three bytes: the address byte, an instruction byte, then one data byte. The instruction byte selects one of two modes. In register mode it writes the data into a wiper or into a shadow entry. In command mode it runs a command on one channel. The only command implemented is restore, which copies shadow entry n into wiper n. A read transfer streams the wipers in order, starting at wiper 0, for as long as the master keeps acknowledging.

The wiper values are available in parallel on an output bus. That bus drives the analog stage, which is outside this block.

Top module: `i2c_wiper_slave`

## Requirements
- R1: After reset, every wiper and every shadow entry holds 8'h80 and `sda_oe` is low.
- R2: The block acknowledges an address byte only when its upper seven bits equal {5'b01011, addr_pins}; bit 0 of that byte is the direction (1 = read). A non-matching transfer gets no acknowledge on any byte, and none of its bytes has any effect.
- R3: In a write, instruction bit 7 = 0 with bit 5 = 0 selects register mode for a wiper. Instruction bits 4:0 in the range 0 to 3 select wiper 0 to 3, and the data byte is stored there.
- R4: Instruction bit 7 = 0 with bit 5 = 1 stores the data byte into shadow entry 0 to 15, chosen by instruction bits 4:0.
- R5: A register-mode address outside the target's range (wiper 4 to 31, shadow 16 to 31) is acknowledged, and the write has no effect.
- R6: Instruction bit 7 = 1 selects command mode, with the code in bits 6:3 and the channel in bits 2:0. Code 4'b0001 with channel 0 to 3 copies the shadow entry of that channel into the wiper of that channel once the data byte is acknowledged; the data value is ignored. Channels 4 to 7 have no effect.
- R7: Any other command code is acknowledged and has no effect.
- R8: In a read, wiper 0 is sent MSB first right after the address acknowledge. Each master ACK moves on to the next wiper, and the sequence wraps from 3 back to 0. A master NACK ends the read and releases the line.
- R9: In a write, the address, instruction and data bytes are each acknowledged during the ninth clock pulse. Any byte after the data byte is not acknowledged and has no effect.
- R10: A stop or a repeated start at any point returns the block to address matching. A write cut short before its data byte changes nothing.
- R11: `sda_oe` changes only while SCL is low, so the driven bit is stable for the whole high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| addr_pins | input | 2 | Strap value for the two low device-address bits |
| sda_oe | output | 1 | When high, the data line is pulled low |
| wiper_o | output | 32 | Wipers 0 to 3 packed, wiper n at bits 8n+7:8n |

## Verification
Address matching is swept over all four strap values against all four low-bit addresses, plus two wrong upper patterns. This tells the correct match apart from one that ignores either the straps or the fixed bits. Register writes are tried on every wiper with zero, all-ones and alternating data. They are also tried at every out-of-range address, which tells a range check apart from an index that has been truncated and aliases back into the array. The restore command is first run before any shadow write, which exposes the shadow reset value, and then after distinct values have been written; every other command code and every channel above 3 are tried and must leave the wipers alone. Reads run past four bytes to exercise the wrap, and writes are cut short by a stop or by a repeated start to show that nothing is committed early.

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave #(
  parameter int          NUM_WIPERS  = 4,
  parameter int          NV_DEPTH    = 16,
  parameter logic [4:0]  DEV_ID      = 5'b01011,
  parameter logic [3:0]  CMD_RESTORE = 4'h1,
  parameter logic [7:0]  RESET_VAL   = 8'h80
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_in,
  input  logic                    sda_in,
  input  logic [1:0]              addr_pins,
  output logic                    sda_oe,
  output logic [NUM_WIPERS*8-1:0] wiper_o
);
  localparam int WI = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1;
  localparam int NI = (NV_DEPTH > 1) ? $clog2(NV_DEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INSTR, S_DATA, S_READ, S_DONE} state_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  state_t     state;
  logic [3:0] cnt;
  logic [7:0] sh, instr, tx;
  logic [WI-1:0] rd_idx;
  logic       mack;
  logic [7:0] wiper [NUM_WIPERS];
  logic [7:0] nv    [NV_DEPTH];

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;

  wire       addr_hit = (sh[7:1] == {DEV_ID, addr_pins});
  wire [4:0] reg_addr = instr[4:0];
  wire [2:0] chan     = instr[2:0];
  wire       wip_ok   = int'(reg_addr) < NUM_WIPERS;
  wire       nv_ok    = int'(reg_addr) < NV_DEPTH;
  wire       chan_ok  = (int'(chan) < NUM_WIPERS) && (int'(chan) < NV_DEPTH);
  wire [WI-1:0] nxt_idx = (int'(rd_idx) == NUM_WIPERS - 1) ? '0 : rd_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      instr  <= '0;
      tx     <= '0;
      rd_idx <= '0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NUM_WIPERS; i++) wiper[i] <= RESET_VAL;
      for (int i = 0; i < NV_DEPTH; i++)   nv[i]    <= RESET_VAL;
    end else if (start_c) begin
      state  <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (state != S_IDLE) begin
      if (scl_rise) begin
        if (cnt < 4'd8) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (cnt == 4'd8) begin
          cnt  <= 4'd9;
          mack <= ~sda_s;
        end
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          case (state)
            S_READ:  sda_oe <= 1'b0;
            S_ADDR:  if (addr_hit) sda_oe <= 1'b1; else state <= S_DONE;
            S_INSTR: begin sda_oe <= 1'b1; instr <= sh; end
            S_DATA: begin
              sda_oe <= 1'b1;
              if (!instr[7]) begin
                if (instr[5]) begin
                  if (nv_ok) nv[reg_addr[NI-1:0]] <= sh;
                end else if (wip_ok) begin
                  wiper[reg_addr[WI-1:0]] <= sh;
                end
              end else if (instr[6:3] == CMD_RESTORE && chan_ok) begin
                wiper[chan[WI-1:0]] <= nv[NI'(chan)];
              end
            end
            default: ;
          endcase
        end else if (cnt == 4'd9) begin
          cnt    <= '0;
          sda_oe <= 1'b0;
          case (state)
            S_ADDR:
              if (sh[0]) begin
                state  <= S_READ;
                rd_idx <= '0;
                tx     <= wiper[0];
                sda_oe <= ~wiper[0][7];
              end else begin
                state <= S_INSTR;
              end
            S_INSTR: state <= S_DATA;
            S_DATA:  state <= S_DONE;
            S_READ:
              if (mack) begin
                rd_idx <= nxt_idx;
                tx     <= wiper[nxt_idx];
                sda_oe <= ~wiper[nxt_idx][7];
              end else begin
                state <= S_DONE;
              end
            default: ;
          endcase
        end else if (cnt != 4'd0 && state == S_READ) begin
          tx     <= {tx[6:0], 1'b0};
          sda_oe <= ~tx[6];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_out
    assign wiper_o[g*8 +: 8] = wiper[g];
  end

  a_r11_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !start_c && !stop_c) |=> $stable(sda_oe));

  a_r9_drive_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && state == S_IDLE));

  a_r2_quiet_when_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_DONE) |-> !sda_oe);

  a_r3_wiper_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |=> $stable(wiper_o));
endmodule

// File: tb/i2c_wiper_slave_tb.sv
`timescale 1ns/1ps
module i2c_wiper_slave_tb;
  localparam int H = 8;
  localparam int Q = 3;
  localparam logic [4:0] DEV = 5'b01011;

  logic clk = 0, rst_n = 0;
  logic scl = 1, m_sda = 1;
  logic [1:0] pins = 2'b10;
  logic sda_oe;
  logic [31:0] wiper_o;
  wire bus_sda = m_sda & ~sda_oe;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_w [4];
  logic [7:0] exp_nv [16];

  always #2 clk = ~clk;

  i2c_wiper_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(bus_sda),
    .addr_pins(pins), .sda_oe(sda_oe), .wiper_o(wiper_o));

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_wipers(input string req);
    for (int c = 0; c < 4; c++) chk(req, wiper_o[c*8 +: 8], exp_w[c]);
  endtask

  task automatic bus_start;
    w(Q); m_sda = 1; w(H); scl = 1; w(H); m_sda = 0; w(H); scl = 0;
  endtask

  task automatic bus_stop;
    w(Q); m_sda = 0; w(H); scl = 1; w(H); m_sda = 1; w(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      w(Q); m_sda = b[i]; w(H); scl = 1; w(H); scl = 0;
    end
    w(Q); m_sda = 1; w(H); scl = 1; w(H/2); acked = ~bus_sda; w(H/2); scl = 0;
  endtask

  task automatic read_byte(input logic ack, output logic [7:0] d, output logic steady);
    logic a, b;
    steady = 1; d = '0;
    for (int i = 0; i < 8; i++) begin
      w(Q); m_sda = 1; w(H); scl = 1; w(2); a = bus_sda; w(H-4); b = bus_sda;
      if (a !== b) steady = 0;
      w(2); scl = 0; d = {d[6:0], a};
    end
    w(Q); m_sda = ~ack; w(H); scl = 1; w(H); scl = 0; w(Q); m_sda = 1;
  endtask

  task automatic wr(input logic [6:0] a7, input logic [7:0] ins, input logic [7:0] d,
                    output logic [2:0] acks);
    bus_start;
    send_byte({a7, 1'b0}, acks[2]);
    send_byte(ins, acks[1]);
    send_byte(d, acks[0]);
    bus_stop;
  endtask

  task automatic restore_all(input string req);
    logic [2:0] k;
    for (int c = 0; c < 4; c++) begin
      wr({DEV, pins}, 8'h88 | 8'(c), 8'h3C, k);
      chk(req, k, 3'b111);
      exp_w[c] = exp_nv[c];
    end
    chk_wipers(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1; fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] k;
    logic a;
    logic [7:0] d;
    logic st;
    for (int i = 0; i < 4; i++) exp_w[i] = 8'h80;
    for (int i = 0; i < 16; i++) exp_nv[i] = 8'h80;
    w(5); rst_n = 1; w(5);

    // R1 reset state
    chk("R1 oe", sda_oe, 0);
    chk_wipers("R1 wipers");

    // R2 address sweep over strap values
    for (int p = 0; p < 4; p++) begin
      pins = 2'(p);
      for (int a2 = 0; a2 < 4; a2++) begin
        bus_start; send_byte({DEV, 2'(a2), 1'b0}, a); bus_stop;
        chk("R2 match", a, (a2 == p));
      end
      bus_start; send_byte({5'b01010, 2'(p), 1'b0}, a); bus_stop;
      chk("R2 upper", a, 0);
      bus_start; send_byte({5'b11011, 2'(p), 1'b1}, a); bus_stop;
      chk("R2 upper rd", a, 0);
    end
    pins = 2'b10;
    wr({DEV, 2'b01}, 8'h00, 8'h11, k);
    chk("R2 foreign acks", k, 3'b000);
    chk_wipers("R2 foreign no effect");

    // R3 wiper writes, R9 acks
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 4; v++) begin
        d = (v == 0) ? 8'h00 : (v == 1) ? 8'hFF : (v == 2) ? 8'h5A : 8'(c * 37 + 1);
        wr({DEV, pins}, 8'(c), d, k);
        chk("R9 acks", k, 3'b111);
        exp_w[c] = d;
        chk_wipers("R3 wiper write");
      end
    end

    // R1 shadow reset seen through R6 restore
    restore_all("R1 shadow reset");

    // R4 shadow writes
    for (int i = 0; i < 16; i++) begin
      wr({DEV, pins}, 8'h20 | 8'(i), 8'(i * 29 + 7), k);
      chk("R4 ack", k, 3'b111);
      exp_nv[i] = 8'(i * 29 + 7);
    end
    for (int c = 0; c < 4; c++) begin
      wr({DEV, pins}, 8'(c), 8'hE0 | 8'(c), k);
      exp_w[c] = 8'hE0 | 8'(c);
    end
    chk_wipers("R3 setup");
    restore_all("R6 restore R4 data");

    // R5 out of range wiper and shadow addresses
    for (int i = 4; i < 32; i++) begin
      wr({DEV, pins}, 8'(i), 8'h11, k);
      chk("R5 wiper ack", k, 3'b111);
    end
    chk_wipers("R5 wiper ignored");
    for (int i = 16; i < 32; i++) begin
      wr({DEV, pins}, 8'h20 | 8'(i), 8'h22, k);
      chk("R5 shadow ack", k, 3'b111);
    end
    restore_all("R5 shadow ignored");

    // R6 channels 4..7 and R7 other codes
    for (int c = 0; c < 4; c++) begin
      wr({DEV, pins}, 8'(c), 8'h40 + 8'(c), k);
      exp_w[c] = 8'h40 + 8'(c);
    end
    for (int c = 4; c < 8; c++) begin
      wr({DEV, pins}, 8'h88 | 8'(c), 8'h00, k);
      chk("R6 high chan ack", k, 3'b111);
    end
    chk_wipers("R6 high chan ignored");
    for (int code = 0; code < 16; code++) begin
      if (code == 1) continue;
      wr({DEV, pins}, 8'h80 | 8'(code << 3), 8'h00, k);
      chk("R7 ack", k, 3'b111);
    end
    chk_wipers("R7 no effect");

    // R9 byte after data not acknowledged
    bus_start;
    send_byte({DEV, pins, 1'b0}, a);
    send_byte(8'h01, a);
    send_byte(8'h99, a);
    exp_w[1] = 8'h99;
    send_byte(8'h55, a);
    chk("R9 extra byte nack", a, 0);
    send_byte(8'h66, a);
    bus_stop;
    chk_wipers("R9 extra ignored");

    // R8 read stream with wrap, R11 steady bits
    bus_start;
    send_byte({DEV, pins, 1'b1}, a);
    chk("R8 addr ack", a, 1);
    for (int n = 0; n < 6; n++) begin
      read_byte(n != 5, d, st);
      chk("R8 read data", d, exp_w[n % 4]);
      chk("R11 steady", st, 1);
    end
    bus_stop;
    chk("R8 released", sda_oe, 0);
    bus_start;
    send_byte({DEV, pins, 1'b1}, a);
    read_byte(1'b0, d, st);
    chk("R8 single nack", d, exp_w[0]);
    bus_stop;

    // R10 aborted writes
    bus_start;
    send_byte({DEV, pins, 1'b0}, a);
    send_byte(8'h02, a);
    bus_stop;
    chk_wipers("R10 stop abort");
    bus_start;
    send_byte({DEV, pins, 1'b0}, a);
    send_byte(8'h00, a);
    bus_start;
    send_byte({DEV, pins, 1'b1}, a);
    chk("R10 restart ack", a, 1);
    read_byte(1'b0, d, st);
    chk("R10 restart read", d, exp_w[0]);
    bus_stop;
    chk_wipers("R10 restart no write");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule